// File: doc/BRIEF.md
# Trapezoid Staircase Edge Generator

This block produces one DAC code per clock. Each code is one sample of a trapezoid that repeats with no gap. Every period passes through four segments: a high plateau, a falling staircase, a low plateau and a rising staircase. Each staircase always takes sixteen equal code steps, so the slope of an edge depends only on the two levels. The two plateau lengths, counted in samples, are the only thing that sets the period. Keeping the edges fixed keeps their timing the same at every frequency, which suits a downstream filter and comparator that turn the edge into a trigger.

The two levels and the two plateau lengths come from shadow inputs. The block copies them into its working settings at one point of the period only: on entry to the high plateau. It also copies them while reset is held. Software may therefore rewrite the shadows at any time without tearing a period. A run enable freezes the sequence in place. When the enable returns, the sequence carries on with no sample skipped or repeated.

The state machine has four states: SEG_HIGH, SEG_FALL, SEG_LOW and SEG_RISE. Its transitions are:

- SEG_HIGH to SEG_FALL after the high plateau count.
- SEG_FALL to SEG_LOW after sixteen edge samples.
- SEG_LOW to SEG_RISE after the low plateau count.
- SEG_RISE to SEG_HIGH after sixteen edge samples. The shadow settings are loaded on this transition.

Reset places the machine in SEG_LOW at count zero.

Top module: `trap_edge_gen`

## Requirements
- R1: While rst_n is low at a clock edge (synchronous reset), dac_code takes the value of shd_lo_code and the machine enters the low plateau at count zero. The shadow settings are loaded at the same time. The first samples after release are the low plateau.
- R2: Segments follow the fixed order high plateau, falling edge, low plateau, rising edge, then back to high plateau. No segment is ever skipped.
- R3: Each edge lasts exactly 16 samples. Let s = (hi - lo) / 16, truncated toward zero. For k = 1..15, rising sample k is lo + k*s and falling sample k is hi - k*s. Sample 16 equals the target level exactly, so the final step carries the remainder.
- R4: The edge samples depend only on the two levels. Two settings with equal levels and different plateau lengths produce identical edges.
- R5: The high plateau outputs the working high level for shd_hi_len samples, as latched.
- R6: The low plateau outputs the working low level for shd_lo_len samples, as latched.
- R7: A plateau length of zero is treated as one sample.
- R8: The shadow levels and lengths take effect only from the first sample of a high plateau, or from reset. Changes at any other time do not alter the samples of the current period.
- R9: While run_en is low, dac_code holds and the sequence does not advance. When run_en returns high, the next sample is the one that would have followed.
- R10: A high level below the low level is legal. The edges then run in the opposite direction under the same R3 formula and stay between the two levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Advance one sample per clock when high; freeze when low |
| shd_hi_code | input | CODE_W | Shadow high level code |
| shd_lo_code | input | CODE_W | Shadow low level code |
| shd_hi_len | input | LEN_W | Shadow high plateau length in samples (0 means 1) |
| shd_lo_len | input | LEN_W | Shadow low plateau length in samples (0 means 1) |
| dac_code | output | CODE_W | Registered DAC code, one sample per enabled clock |

## Verification
The bench uses level differences that are not multiples of sixteen, including a full-scale swing. A design that floors instead of truncating, or that drops the remainder, misses the last step or overshoots the target. It rewrites the shadow inputs in the middle of a period; a design that loads them early would bend the running edge or plateau. It also covers zero plateau lengths, which a wrong design would stretch to a full counter wrap. It covers inverted levels, where an unsigned step would blow up. Finally, it drops run_en in the middle of an edge, where a wrong design would skip or repeat a stair sample.

// File: rtl/trap_pkg.sv
package trap_pkg;

    // Segment codes; the numeric order follows the waveform sequence.
    typedef enum logic [1:0] {
        SEG_HIGH = 2'd0,
        SEG_FALL = 2'd1,
        SEG_LOW  = 2'd2,
        SEG_RISE = 2'd3
    } seg_e;

    function automatic seg_e seg_successor(seg_e s);
        seg_e n;
        unique case (s)
            SEG_HIGH: n = SEG_FALL;
            SEG_FALL: n = SEG_LOW;
            SEG_LOW:  n = SEG_RISE;
            SEG_RISE: n = SEG_HIGH;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/trap_step_calc.sv
// Signed per-stair increment: (hi - lo) / 2**STEP_LOG2, truncated toward zero.
module trap_step_calc #(
    parameter int CODE_W    = 16,
    parameter int STEP_LOG2 = 4
) (
    input  logic [CODE_W-1:0]        hi,
    input  logic [CODE_W-1:0]        lo,
    output logic signed [CODE_W:0]   step
);
    localparam int SW = CODE_W + 1;

    logic signed [SW-1:0] diff;
    logic        [SW-1:0] mag;
    logic        [SW-1:0] mag_sh;

    always_comb begin
        diff   = $signed({1'b0, hi}) - $signed({1'b0, lo});
        mag    = diff[SW-1] ? SW'(-diff) : SW'(diff);
        mag_sh = mag >> STEP_LOG2;
        step   = diff[SW-1] ? -$signed(mag_sh) : $signed(mag_sh);
    end
endmodule

// File: rtl/trap_seq_fsm.sv
// Segment sequencer: state register, segment counter, working settings.
module trap_seq_fsm
    import trap_pkg::*;
#(
    parameter int CODE_W    = 16,
    parameter int LEN_W     = 16,
    parameter int STEP_LOG2 = 4,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [CODE_W-1:0] shd_hi_code,
    input  logic [CODE_W-1:0] shd_lo_code,
    input  logic [LEN_W-1:0]  shd_hi_len,
    input  logic [LEN_W-1:0]  shd_lo_len,
    output seg_e              seg_q,
    output logic [CNT_W-1:0]  idx_q,
    output logic [CODE_W-1:0] act_hi,
    output logic [CODE_W-1:0] act_lo
);
    localparam int              STEPS     = 1 << STEP_LOG2;
    localparam logic [CNT_W-1:0] EDGE_LAST = CNT_W'(STEPS - 1);

    logic [LEN_W-1:0] act_hlen;
    logic [LEN_W-1:0] act_llen;
    logic [CNT_W-1:0] hlast;
    logic [CNT_W-1:0] llast;
    seg_e             seg_d;
    logic [CNT_W-1:0] idx_d;
    logic             load_d;

    // Zero length behaves as a single sample.
    always_comb begin
        hlast = (act_hlen == '0) ? '0 : CNT_W'(act_hlen) - CNT_W'(1);
        llast = (act_llen == '0) ? '0 : CNT_W'(act_llen) - CNT_W'(1);
    end

    always_comb begin
        seg_d  = seg_q;
        idx_d  = idx_q;
        load_d = 1'b0;
        if (run_en) begin
            unique case (seg_q)
                SEG_HIGH: begin
                    if (idx_q >= hlast) begin
                        seg_d = SEG_FALL;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + CNT_W'(1);
                    end
                end
                SEG_FALL: begin
                    if (idx_q == EDGE_LAST) begin
                        seg_d = SEG_LOW;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + CNT_W'(1);
                    end
                end
                SEG_LOW: begin
                    if (idx_q >= llast) begin
                        seg_d = SEG_RISE;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + CNT_W'(1);
                    end
                end
                SEG_RISE: begin
                    if (idx_q == EDGE_LAST) begin
                        seg_d  = SEG_HIGH;
                        idx_d  = '0;
                        load_d = 1'b1;
                    end else begin
                        idx_d = idx_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= SEG_LOW;
            idx_q <= '0;
        end else begin
            seg_q <= seg_d;
            idx_q <= idx_d;
        end
    end

    // Working settings: copied from the shadows in reset and at high-plateau entry
    always_ff @(posedge clk) begin
        if (!rst_n || load_d) begin
            act_hi   <= shd_hi_code;
            act_lo   <= shd_lo_code;
            act_hlen <= shd_hi_len;
            act_llen <= shd_lo_len;
        end
    end
endmodule

// File: rtl/trap_level_gen.sv
// Output stage: code for the current segment and stair, registered per enabled clock.
module trap_level_gen
    import trap_pkg::*;
#(
    parameter int CODE_W    = 16,
    parameter int STEP_LOG2 = 4,
    parameter int CNT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_en,
    input  seg_e                   seg,
    input  logic [CNT_W-1:0]       idx,
    input  logic [CODE_W-1:0]      act_hi,
    input  logic [CODE_W-1:0]      act_lo,
    input  logic signed [CODE_W:0] step,
    input  logic [CODE_W-1:0]      shd_lo_code,
    output logic [CODE_W-1:0]      dac_code
);
    localparam int STEPS = 1 << STEP_LOG2;
    localparam int SW    = CODE_W + 1;
    localparam int PW    = CODE_W + STEP_LOG2 + 3;

    logic signed [PW-1:0] kk;
    logic signed [PW-1:0] step_ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] up_val;
    logic signed [PW-1:0] dn_val;
    logic                 edge_end;
    logic [CODE_W-1:0]    lvl;

    always_comb begin
        kk       = $signed(PW'(idx[STEP_LOG2-1:0])) + $signed(PW'(1));
        step_ext = {{(PW-SW){step[SW-1]}}, step};
        prod     = kk * step_ext;
        up_val   = $signed({{(PW-CODE_W){1'b0}}, act_lo}) + prod;
        dn_val   = $signed({{(PW-CODE_W){1'b0}}, act_hi}) - prod;
        edge_end = (idx == CNT_W'(STEPS - 1));
    end

    always_comb begin
        unique case (seg)
            SEG_HIGH: lvl = act_hi;
            SEG_LOW:  lvl = act_lo;
            SEG_RISE: lvl = edge_end ? act_hi : up_val[CODE_W-1:0];
            SEG_FALL: lvl = edge_end ? act_lo : dn_val[CODE_W-1:0];
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code <= shd_lo_code;
        end else if (run_en) begin
            dac_code <= lvl;
        end
    end
endmodule

// File: rtl/trap_edge_gen.sv
module trap_edge_gen
    import trap_pkg::*;
#(
    parameter int CODE_W    = 16,
    parameter int LEN_W     = 16,
    parameter int STEP_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [CODE_W-1:0] shd_hi_code,
    input  logic [CODE_W-1:0] shd_lo_code,
    input  logic [LEN_W-1:0]  shd_hi_len,
    input  logic [LEN_W-1:0]  shd_lo_len,
    output logic [CODE_W-1:0] dac_code
);
    localparam int CNT_W = (LEN_W > STEP_LOG2 + 1) ? LEN_W : STEP_LOG2 + 1;

    seg_e                   seg_q;
    logic [CNT_W-1:0]       idx_q;
    logic [CODE_W-1:0]      act_hi;
    logic [CODE_W-1:0]      act_lo;
    logic signed [CODE_W:0] step;

    trap_seq_fsm #(
        .CODE_W(CODE_W), .LEN_W(LEN_W), .STEP_LOG2(STEP_LOG2), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .shd_hi_code(shd_hi_code), .shd_lo_code(shd_lo_code),
        .shd_hi_len(shd_hi_len), .shd_lo_len(shd_lo_len),
        .seg_q(seg_q), .idx_q(idx_q), .act_hi(act_hi), .act_lo(act_lo)
    );

    trap_step_calc #(
        .CODE_W(CODE_W), .STEP_LOG2(STEP_LOG2)
    ) u_step (
        .hi(act_hi), .lo(act_lo), .step(step)
    );

    trap_level_gen #(
        .CODE_W(CODE_W), .STEP_LOG2(STEP_LOG2), .CNT_W(CNT_W)
    ) u_level (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .seg(seg_q), .idx(idx_q), .act_hi(act_hi), .act_lo(act_lo),
        .step(step), .shd_lo_code(shd_lo_code), .dac_code(dac_code)
    );
endmodule

// File: rtl/trap_edge_gen_chk.sv
module trap_edge_gen_chk
    import trap_pkg::*;
#(
    parameter int CODE_W    = 16,
    parameter int STEP_LOG2 = 4,
    parameter int CNT_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input seg_e              seg,
    input logic [CNT_W-1:0]  idx,
    input logic [CODE_W-1:0] act_hi,
    input logic [CODE_W-1:0] act_lo,
    input logic [CODE_W-1:0] dac_code,
    input logic [CODE_W-1:0] shd_lo_code
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'((1 << STEP_LOG2) - 1);

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (dac_code == $past(shd_lo_code)) && (seg == SEG_LOW) && (idx == '0)); // R1

    AST_SEG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> (seg == $past(seg)) || (seg == seg_successor($past(seg)))); // R2

    AST_EDGE_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == SEG_RISE || seg == SEG_FALL) |-> (idx <= LAST)); // R3

    AST_RISE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && seg == SEG_RISE && idx == LAST) |=> (dac_code == $past(act_hi))); // R3

    AST_FALL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && seg == SEG_FALL && idx == LAST) |=> (dac_code == $past(act_lo))); // R3

    AST_LOAD_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (act_hi != $past(act_hi) || act_lo != $past(act_lo)))
            |-> (seg == SEG_HIGH && idx == '0)); // R8

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(dac_code) && $stable(seg) && $stable(idx)); // R9
endmodule

bind trap_edge_gen trap_edge_gen_chk #(
    .CODE_W(CODE_W), .STEP_LOG2(STEP_LOG2), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .seg(seg_q), .idx(idx_q),
    .act_hi(act_hi), .act_lo(act_lo), .dac_code(dac_code), .shd_lo_code(shd_lo_code)
);

// File: tb/test_trap_edge_gen.sv
module test_trap_edge_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 16;
    localparam int LEN_W      = 16;
    localparam int NSTEP      = 16;
    localparam int NVEC       = 6;

    // {high level, low level, high length, low length}
    localparam int VEC [NVEC][4] = '{
        '{1000,  0,    3, 2},
        '{1000,  0,    7, 5},
        '{65535, 0,    0, 0},
        '{5000,  4990, 1, 1},
        '{100,   3000, 2, 4},
        '{40000, 12345, 4, 3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_en = 1'b1;
    logic [CODE_W-1:0] shd_hi_code = '0;
    logic [CODE_W-1:0] shd_lo_code = '0;
    logic [LEN_W-1:0]  shd_hi_len = '0;
    logic [LEN_W-1:0]  shd_lo_len = '0;
    logic [CODE_W-1:0] dac_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trap_edge_gen #(.CODE_W(CODE_W), .LEN_W(LEN_W), .STEP_LOG2(4)) i_trap_edge_gen (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .shd_hi_code(shd_hi_code), .shd_lo_code(shd_lo_code),
        .shd_hi_len(shd_hi_len), .shd_lo_len(shd_lo_len),
        .dac_code(dac_code)
    );

    task automatic chk(input int exp, input string req);
        @(negedge clk);
        n_checks++;
        if (int'(dac_code) != exp) begin
            n_fail++;
            $display("FAIL %s: dac_code=%0d expected %0d", req, dac_code, exp);
        end
    endtask

    function automatic int edge_val(input int hi, input int lo, input int k, input bit rising);
        int s;
        s = (hi - lo) / NSTEP;
        if (k == NSTEP) return rising ? hi : lo;
        return rising ? lo + k * s : hi - k * s;
    endfunction

    task automatic set_shadow(input int hi, input int lo, input int hl, input int ll);
        shd_hi_code = CODE_W'(hi);
        shd_lo_code = CODE_W'(lo);
        shd_hi_len  = LEN_W'(hl);
        shd_lo_len  = LEN_W'(ll);
    endtask

    task automatic chk_plateau(input int lvl, input int len, input string req);
        int eff;
        eff = (len == 0) ? 1 : len;
        for (int j = 0; j < eff; j++) chk(lvl, req);
    endtask

    task automatic chk_edge(input int hi, input int lo, input bit rising, input string req);
        for (int k = 1; k <= NSTEP; k++) chk(edge_val(hi, lo, k, rising), req);
    endtask

    initial begin
        // Reset state
        set_shadow(800, 160, 2, 3);
        rst_n  = 1'b0;
        run_en = 1'b1;
        @(negedge clk);
        chk(160, "R1 output during reset");
        rst_n = 1'b1;
        // New shadows now must not touch the first low plateau or first rise
        set_shadow(VEC[0][0], VEC[0][1], VEC[0][2], VEC[0][3]);
        chk_plateau(160, 3, "R1 R6 R8 low plateau after reset");
        chk_edge(800, 160, 1'b1, "R3 R8 first rise on reset-time levels");

        // Vector table walk: one full period per entry
        for (int i = 0; i < NVEC; i++) begin
            int hi, lo, hl, ll, nx;
            hi = VEC[i][0]; lo = VEC[i][1]; hl = VEC[i][2]; ll = VEC[i][3];
            nx = (i + 1 < NVEC) ? i + 1 : i;
            chk_plateau(hi, hl, (hl == 0) ? "R7 R5 zero high length" : "R5 R8 high plateau");
            set_shadow(VEC[nx][0], VEC[nx][1], VEC[nx][2], VEC[nx][3]);
            chk_edge(hi, lo, 1'b0, (hi < lo) ? "R10 inverted fall" : "R3 R4 R2 fall");
            chk_plateau(lo, ll, (ll == 0) ? "R7 R6 zero low length" : "R6 R8 low plateau");
            chk_edge(hi, lo, 1'b1, (hi < lo) ? "R10 inverted rise" : "R3 R4 R2 rise");
        end

        // Freeze in the middle of a falling edge
        chk_plateau(40000, 4, "R5 high before freeze");
        for (int k = 1; k <= 5; k++) chk(edge_val(40000, 12345, k, 1'b0), "R3 fall before freeze");
        run_en = 1'b0;
        for (int j = 0; j < 4; j++) chk(edge_val(40000, 12345, 5, 1'b0), "R9 hold while disabled");
        run_en = 1'b1;
        for (int k = 6; k <= NSTEP; k++) chk(edge_val(40000, 12345, k, 1'b0), "R9 resume without skip");
        chk_plateau(12345, 3, "R9 R6 low after resume");

        // Reset in the middle of a run
        set_shadow(2222, 1111, 1, 1);
        rst_n = 1'b0;
        chk(1111, "R1 mid-run reset level");
        chk(1111, "R1 reset held");
        rst_n = 1'b1;
        chk_plateau(1111, 1, "R1 low plateau first");
        chk_edge(2222, 1111, 1'b1, "R3 rise after reset");
        chk(2222, "R5 high after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule